// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between an internal single-word request bus and an external asynchronous static RAM of 131,072 sixteen-bit words. It turns each accepted request into a cycle-accurate sequence of active-low chip-enable, output-enable, write-enable and per-byte-lane select strobes. It also runs the data-bus tri-state control, captures read data and signals completion with a one-cycle done pulse. Every analog timing minimum of the RAM is a nanosecond parameter. The controller converts each one to a whole number of clock cycles by rounding up against the clock period.

Requests use a valid/ready handshake. Each carries an address, a write flag, sixteen bits of write data and a two-bit byte-enable mask, where bit 0 selects data bits 7:0 (lower lane) and bit 1 selects bits 15:8 (upper lane). The bidirectional RAM data bus is split at the block edge into an output word, an output-enable and an input word; the pad that joins them lies outside the block. With the default 8 ns clock, a read holds its strobes for 7 cycles and is followed by 4 float cycles. A write holds its strobes for 7 cycles and is followed by 1 release cycle.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and after reset, with no request, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n and mem_lb_n are all 1, mem_dq_oe is 0, req_ready is 1 and rsp_done is 0.
- R2: An accepted read with a non-zero mask drives mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC cycles, where RD_CYC = ceil(max(55, 55, 30) ns / 8 ns) = 7. The lane selects are mem_lb_n = !mask[0] and mem_ub_n = !mask[1].
- R3: Read data is sampled in the last strobe cycle. In the next cycle rsp_done is 1 for one cycle and rsp_rdata holds the RAM bits of each selected lane, with unselected lanes reading 0.
- R4: An accepted write with a non-zero mask drives mem_ce_n=0, mem_we_n=0, mem_oe_n=1, lane selects from the mask, mem_dq_oe=1 and mem_dq_o = write data for WR_CYC = ceil(max(45, 45, 50, 25) ns / 8 ns) = 7 cycles. All write strobes then rise on the same edge.
- R5: After the write strobes rise, the data drivers stay on for one release cycle with all strobes high. In the following cycle mem_dq_oe is 0, rsp_done is 1 and req_ready is 1.
- R6: After a read, all strobes stay high and req_ready stays 0 for FLOAT_CYC = ceil(25 ns / 8 ns) = 4 cycles. mem_dq_oe is never 1 while mem_oe_n is 0.
- R7: A request with mask 2'b00 causes no strobe activity. rsp_done is 1 in the next cycle, req_ready stays 1, a null read returns rsp_rdata = 0, and a null write leaves the RAM contents unchanged.
- R8: mem_addr, mem_ub_n and mem_lb_n stay constant while mem_ce_n is 0, and mem_addr equals the address of the accepted request.
- R9: req_ready is 0 for every cycle of a RAM access. A request held valid while req_ready is 0 produces no strobe change and is accepted once req_ready returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane mask, bit 0 lower lane, bit 1 upper lane |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_dq_o | output | 16 | Data driven towards the RAM |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_i | input | 16 | Data received from the RAM |

## Verification
The hardest case to reach from the ports is a request that arrives while the bus is still floating after a read. The bench raises req_valid with a write request during the float window of a read. It then checks every cycle that neither the strobes nor the drivers move until req_ready returns, and that the write is only taken afterwards. Partial-lane writes to the same word, each followed by full and single-lane reads, show that unselected lanes are left untouched and read back as zero. A random mix of reads, writes and null requests over a small set of colliding addresses covers back-to-back turnarounds in both directions.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_FLOAT,
        ST_WRITE,
        ST_RELEASE
    } seq_state_e;

    // Whole clock cycles needed to cover t_ns, never less than one.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] wbyte_i,
    input  logic         cap_i,
    input  logic         sel_n_i,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] rbyte_o
);

    typedef struct packed {
        logic [W-1:0] wr;
        logic [W-1:0] rd;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (load_i) begin
            lane_d.wr = wbyte_i;
            lane_d.rd = '0;
        end
        if (cap_i && !sel_n_i) begin
            lane_d.rd = pin_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign pin_o   = lane_q.wr;
    assign rbyte_o = lane_q.rd;

    // R3: a deselected lane never picks up bus data during a capture
    assert_lane_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cap_i && sel_n_i && !load_i) |=> (rbyte_o == '0))
        else $error("deselected lane captured data");

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int LANES     = 2,
    parameter int RD_CYC    = 7,
    parameter int WR_CYC    = 7,
    parameter int FLOAT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ready,
    output logic              accept_o,
    output logic              cap_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LANES-1:0]  sel_n_o,
    output logic              ce_n_o,
    output logic              oe_n_o,
    output logic              we_n_o,
    output logic              drive_o
);

    localparam int MAX_CYC = (RD_CYC > WR_CYC) ? ((RD_CYC > FLOAT_CYC) ? RD_CYC : FLOAT_CYC)
                                               : ((WR_CYC > FLOAT_CYC) ? WR_CYC : FLOAT_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  sel_n;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              drive;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept_w;
    logic cap_w;

    assign accept_w = req_valid && (seq_q.st == ST_IDLE);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        cap_w      = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_be == '0) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.addr  = req_addr;
                        seq_d.sel_n = ~req_be;
                        seq_d.ce_n  = 1'b0;
                        if (req_write) begin
                            seq_d.st    = ST_WRITE;
                            seq_d.we_n  = 1'b0;
                            seq_d.drive = 1'b1;
                            seq_d.cnt   = CNT_W'(WR_CYC - 1);
                        end else begin
                            seq_d.st   = ST_READ;
                            seq_d.oe_n = 1'b0;
                            seq_d.cnt  = CNT_W'(RD_CYC - 1);
                        end
                    end
                end
            end
            ST_READ: begin
                if (seq_q.cnt == '0) begin
                    cap_w       = 1'b1;
                    seq_d.done  = 1'b1;
                    seq_d.ce_n  = 1'b1;
                    seq_d.oe_n  = 1'b1;
                    seq_d.sel_n = '1;
                    seq_d.st    = ST_FLOAT;
                    seq_d.cnt   = CNT_W'(FLOAT_CYC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_FLOAT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_WRITE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ce_n  = 1'b1;
                    seq_d.we_n  = 1'b1;
                    seq_d.sel_n = '1;
                    seq_d.st    = ST_RELEASE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_RELEASE: begin
                seq_d.drive = 1'b0;
                seq_d.done  = 1'b1;
                seq_d.st    = ST_IDLE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.st    <= ST_IDLE;
            seq_q.cnt   <= '0;
            seq_q.addr  <= '0;
            seq_q.sel_n <= '1;
            seq_q.ce_n  <= 1'b1;
            seq_q.oe_n  <= 1'b1;
            seq_q.we_n  <= 1'b1;
            seq_q.drive <= 1'b0;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == ST_IDLE);
    assign accept_o  = accept_w;
    assign cap_o     = cap_w;
    assign done_o    = seq_q.done;
    assign addr_o    = seq_q.addr;
    assign sel_n_o   = seq_q.sel_n;
    assign ce_n_o    = seq_q.ce_n;
    assign oe_n_o    = seq_q.oe_n;
    assign we_n_o    = seq_q.we_n;
    assign drive_o   = seq_q.drive;

    // R6: the controller never drives while the RAM may drive
    assert_no_contention_R6: assert property (@(posedge clk) disable iff (rst)
        drive_o |-> oe_n_o)
        else $error("data drivers on while output enable asserted");

    // R4: a write strobe only appears inside a full, driven write overlap
    assert_write_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !we_n_o |-> (!ce_n_o && oe_n_o && drive_o && (sel_n_o != '1)))
        else $error("write enable outside a valid write overlap");

    // R2: output enable only with chip enable and no write strobe
    assert_read_strobes_R2: assert property (@(posedge clk) disable iff (rst)
        !oe_n_o |-> (!ce_n_o && we_n_o))
        else $error("output enable outside a read");

    // R5: data still driven on the cycle the write strobe rises
    assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n_o) |-> drive_o)
        else $error("data released before write end");

    // R8: address and lane selects frozen while the chip is enabled
    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!ce_n_o && $past(!ce_n_o)) |-> ($stable(addr_o) && $stable(sel_n_o)))
        else $error("address or lane select moved during access");

    // R7: an empty mask completes without enabling the chip
    assert_null_request_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_be == '0)) |=> (ce_n_o && done_o && req_ready))
        else $error("null request touched the RAM");

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int LANE_W    = 8,
    parameter int CLK_NS    = 8,
    parameter int T_AA_NS   = 55,
    parameter int T_ACE_NS  = 55,
    parameter int T_DOE_NS  = 30,
    parameter int T_WC_NS   = 55,
    parameter int T_WP_NS   = 45,
    parameter int T_BW_NS   = 45,
    parameter int T_AW_NS   = 50,
    parameter int T_SD_NS   = 25,
    parameter int T_HZ_NS   = 25
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    input  logic [1:0]          req_be,
    output logic                rsp_done,
    output logic [2*LANE_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic                mem_ub_n,
    output logic                mem_lb_n,
    output logic [2*LANE_W-1:0] mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [2*LANE_W-1:0] mem_dq_i
);

    localparam int LANES = 2;
    localparam int RD_CYC = int'(umax(ns_to_cyc(T_AA_NS, CLK_NS),
                                 umax(ns_to_cyc(T_ACE_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS))));
    // One release cycle follows the strobes, so the strobes cover the cycle time less one.
    localparam int WC_STROBE = (ns_to_cyc(T_WC_NS, CLK_NS) > 1) ? int'(ns_to_cyc(T_WC_NS, CLK_NS)) - 1 : 1;
    localparam int WR_CYC = int'(umax(umax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_BW_NS, CLK_NS)),
                                 umax(umax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                      WC_STROBE)));
    localparam int FLOAT_CYC = int'(ns_to_cyc(T_HZ_NS, CLK_NS));

    logic             accept_w;
    logic             cap_w;
    logic [LANES-1:0] sel_n_w;

    sram_seq_fsm #(
        .ADDR_W    (ADDR_W),
        .LANES     (LANES),
        .RD_CYC    (RD_CYC),
        .WR_CYC    (WR_CYC),
        .FLOAT_CYC (FLOAT_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_ready (req_ready),
        .accept_o  (accept_w),
        .cap_o     (cap_w),
        .done_o    (rsp_done),
        .addr_o    (mem_addr),
        .sel_n_o   (sel_n_w),
        .ce_n_o    (mem_ce_n),
        .oe_n_o    (mem_oe_n),
        .we_n_o    (mem_we_n),
        .drive_o   (mem_dq_oe)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_io #(.W(LANE_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .load_i  (accept_w),
            .wbyte_i (req_wdata[g*LANE_W +: LANE_W]),
            .cap_i   (cap_w),
            .sel_n_i (sel_n_w[g]),
            .pin_i   (mem_dq_i[g*LANE_W +: LANE_W]),
            .pin_o   (mem_dq_o[g*LANE_W +: LANE_W]),
            .rbyte_o (rsp_rdata[g*LANE_W +: LANE_W])
        );
    end

    assign mem_lb_n = sel_n_w[0];
    assign mem_ub_n = sel_n_w[1];

endmodule

// File: tb/tb_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_sram_strobe_ctrl;

    localparam int CLK_NS  = 8;
    localparam int RD_CYC  = (55 + CLK_NS - 1) / CLK_NS;
    localparam int WR_CYC  = (50 + CLK_NS - 1) / CLK_NS;
    localparam int FLT_CYC = (25 + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_i;

    sram_strobe_ctrl dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Pin vector: ce_n, oe_n, we_n, ub_n, lb_n, dq_oe, ready, done
    task automatic expect_pins(input string req, input bit ce, input bit oe, input bit we,
                               input logic [1:0] seln, input bit drv, input bit rdy, input bit dn);
        logic [7:0] act, exp;
        act = {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready, rsp_done};
        exp = {ce, oe, we, seln[1], seln[0], drv, rdy, dn};
        chk(act === exp, req, "pins", {24'h0, act}, {24'h0, exp});
    endtask

    // Behavioural RAM at the far end of the bus
    logic [15:0] ram    [int];
    logic [15:0] shadow [int];
    int          ram_gen = 0;
    bit          was_ovl = 1'b0;
    logic [16:0] lat_a;
    logic [15:0] lat_d;
    logic [1:0]  lat_sel;

    function automatic logic [15:0] ram_word(input logic [16:0] a);
        return ram.exists(int'(a)) ? ram[int'(a)] : 16'h0000;
    endfunction

    function automatic logic [15:0] shadow_word(input logic [16:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    always @(mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_addr, ram_gen) begin
        logic [15:0] w;
        w = ram_word(mem_addr);
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_i = {mem_ub_n ? 8'hC3 : w[15:8], mem_lb_n ? 8'h5A : w[7:0]};
        else
            mem_dq_i = 16'h3C96;
    end

    always @(negedge clk) begin
        bit ovl;
        if (!rst) begin
            ovl = !mem_ce_n && !mem_we_n && !(mem_ub_n && mem_lb_n);
            chk(!(mem_dq_oe && !mem_oe_n), "R6", "contention", {31'h0, mem_dq_oe}, 32'h0);
            if (ovl) begin
                lat_a   = mem_addr;
                lat_d   = mem_dq_o;
                lat_sel = {mem_ub_n, mem_lb_n};
            end else if (was_ovl) begin
                logic [15:0] old;
                old = ram_word(lat_a);
                ram[int'(lat_a)] = {lat_sel[1] ? old[15:8] : lat_d[15:8],
                                    lat_sel[0] ? old[7:0]  : lat_d[7:0]};
                ram_gen++;
                chk(mem_dq_oe === 1'b1, "R5", "data hold after write end", {31'h0, mem_dq_oe}, 32'h1);
            end
            was_ovl = ovl;
        end
    end

    task automatic do_read(input logic [16:0] a, input logic [1:0] m,
                           input bit stall, input logic [16:0] na, input logic [15:0] nd,
                           input logic [1:0] nm);
        logic [15:0] exp;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = m; req_wdata = 16'hFFFF;
        chk(req_ready === 1'b1, "R9", "ready before read", {31'h0, req_ready}, 32'h1);
        @(negedge clk);
        req_valid = 1'b0;
        if (m == 2'b00) begin
            expect_pins("R7", 1, 1, 1, 2'b11, 0, 1, 1);
            chk(rsp_rdata === 16'h0, "R7", "null read data", {16'h0, rsp_rdata}, 32'h0);
            return;
        end
        for (int k = 0; k < RD_CYC; k++) begin
            expect_pins("R2", 0, 0, 1, ~m, 0, 0, 0);
            chk(mem_addr === a, "R8", "read address", {15'h0, mem_addr}, {15'h0, a});
            @(negedge clk);
        end
        exp = shadow_word(a) & lane_mask(m);
        chk(rsp_rdata === exp, "R3", "read data", {16'h0, rsp_rdata}, {16'h0, exp});
        for (int k = 0; k < FLT_CYC; k++) begin
            expect_pins("R6", 1, 1, 1, 2'b11, 0, 0, k == 0);
            if (stall && k == 0) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = na; req_wdata = nd; req_be = nm;
            end
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [16:0] a, input logic [15:0] w, input logic [1:0] m);
        logic [15:0] old;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = m; req_wdata = w;
        chk(req_ready === 1'b1, "R9", "ready before write", {31'h0, req_ready}, 32'h1);
        @(negedge clk);
        req_valid = 1'b0;
        if (m == 2'b00) begin
            expect_pins("R7", 1, 1, 1, 2'b11, 0, 1, 1);
            return;
        end
        for (int k = 0; k < WR_CYC; k++) begin
            expect_pins("R4", 0, 1, 0, ~m, 1, 0, 0);
            chk(mem_dq_o === w, "R4", "write data", {16'h0, mem_dq_o}, {16'h0, w});
            chk(mem_addr === a, "R8", "write address", {15'h0, mem_addr}, {15'h0, a});
            @(negedge clk);
        end
        expect_pins("R5", 1, 1, 1, 2'b11, 1, 0, 0);
        @(negedge clk);
        expect_pins("R5", 1, 1, 1, 2'b11, 0, 1, 1);
        old = shadow_word(a);
        shadow[int'(a)] = (old & ~lane_mask(m)) | (w & lane_mask(m));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_pins("R1", 1, 1, 1, 2'b11, 0, 1, 0);
        rst = 1'b0;
        @(negedge clk);
        expect_pins("R1", 1, 1, 1, 2'b11, 0, 1, 0);
        @(negedge clk);
        expect_pins("R1", 1, 1, 1, 2'b11, 0, 1, 0);

        do_write(17'h00010, 16'h1234, 2'b11);
        do_read (17'h00010, 2'b11, 0, '0, '0, '0);
        do_read (17'h00010, 2'b01, 0, '0, '0, '0);
        do_read (17'h00010, 2'b10, 0, '0, '0, '0);
        do_write(17'h00010, 16'hABCD, 2'b01);
        do_read (17'h00010, 2'b11, 0, '0, '0, '0);
        do_write(17'h00010, 16'h5566, 2'b10);
        do_read (17'h00010, 2'b11, 0, '0, '0, '0);
        do_write(17'h00010, 16'hFFFF, 2'b00);
        do_read (17'h00010, 2'b11, 0, '0, '0, '0);
        do_read (17'h00010, 2'b00, 0, '0, '0, '0);
        do_write(17'h1FFFF, 16'hCAFE, 2'b11);
        do_write(17'h00000, 16'h0F0F, 2'b11);
        do_read (17'h1FFFF, 2'b11, 0, '0, '0, '0);
        do_read (17'h00000, 2'b11, 1, 17'h00020, 16'h7788, 2'b11);
        do_write(17'h00020, 16'h7788, 2'b11);
        do_read (17'h00020, 2'b11, 0, '0, '0, '0);

        for (int i = 0; i < 60; i++) begin
            logic [16:0] a;
            logic [1:0]  m;
            a = {$urandom_range(0, 1) == 1 ? 2'b11 : 2'b00, 12'h0, 3'($urandom_range(0, 7))};
            m = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) do_write(a, 16'($urandom), m);
            else                           do_read(a, m, 0, '0, '0, '0);
        end

        @(negedge clk);
        expect_pins("R1", 1, 1, 1, 2'b11, 0, 1, 0);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule